// File: doc/BRIEF.md
# Switch Overcurrent and Underload Protection Timer

This block holds the protection timing for a bank of power switches arranged as half-bridges. Each half-bridge has one low-side and one high-side switch. A control frame, applied on a one-cycle load pulse, sets which switches are commanded on. The block turns each commanded switch into a gate-drive level. It delays low-side turn-on so that the partner high-side switch is already off. A frame that asks for both switches of one half-bridge drives neither.

Every switch has a synchronous overcurrent comparator flag. When the overcurrent lockout enable is set and a driven switch reports overcurrent for an unbroken run of dead-time ticks, the switch is forced off and stays off until the next frame. The block also sends a one-cycle overload request to the status register. The drive readback shows which switch was cut. With the lockout enable clear, no cutoff happens and the switch keeps running.

Underload flags are ignored during a blanking window that every frame load restarts. The window is the same for all switches. After it closes, an underload flag on any driven switch raises a shared underload request. All timing counts ticks of an external prescaled enable, for example 1 µs.

Top module: `sw_prot_timer`

## Requirements
- R1: With `oc_lock_en_i` high, a driven switch whose overcurrent flag stays high for OC_TICKS ticks is driven off at the clock edge of the last of those ticks.
- R2: With `oc_lock_en_i` low, overcurrent flags never turn a driven switch off and never raise `overload_req_o`.
- R3: `overload_req_o` is high for exactly one cycle, in the same cycle that the cut switch's `drive_o` bit first reads low.
- R4: If the overcurrent flag drops for a tick before the dead time runs out, the count restarts: a fresh run of OC_TICKS ticks is needed for a cutoff.
- R5: Every frame load restarts an underload blanking window of UL_TICKS ticks that is shared by all switches. `underload_req_o` goes high one cycle after the window closes, while any driven switch (low-side or high-side) has its underload flag set. Flags on switches that are not driven are ignored.
- R6: A commanded low-side switch starts driving LS_DELAY ticks after its request first appears (the frame load edge). A high-side switch drives on the frame load edge itself.
- R7: A switch that was cut off stays off, whatever its flags do, until a later frame load commands it on again.
- R8: Bit 2k of `cmd_on_i` and `drive_o` is the low-side switch of half-bridge k, and bit 2k+1 is its high-side switch. A frame with both bits of a pair set drives neither, and the two bits of a pair are never high at the same time.
- R9: Counters advance only in cycles where `tick_i` is high. With `tick_i` held low, no cutoff, no low-side turn-on and no end of blanking ever occurs.
- R10: After reset every `drive_o` bit and both request outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Prescaled timebase enable, one cycle per time unit |
| frame_load_i | input | 1 | One-cycle pulse: take `cmd_on_i` as the new frame and restart blanking |
| cmd_on_i | input | 2*NUM_HB | Commanded on state per switch (bit 2k low-side, bit 2k+1 high-side) |
| oc_lock_en_i | input | 1 | Overcurrent cutoff enable |
| oc_flag_i | input | 2*NUM_HB | Synchronous overcurrent comparator flags |
| ul_flag_i | input | 2*NUM_HB | Synchronous underload comparator flags |
| drive_o | output | 2*NUM_HB | Gate drive per switch, also the on/off readback |
| overload_req_o | output | 1 | One-cycle request to set the overload status flag |
| underload_req_o | output | 1 | Request to set the underload status flag |

## Verification
The bench sweeps the exact tick counts around each window: the LS_DELAY turn-on, the cycle on which the OC_TICKS cutoff happens, and both sides of the UL_TICKS blanking edge. An off-by-one counter would show up one cycle early or late. A one-tick gap in the overcurrent flag checks that the count restarts. A design that only paused its count would cut the switch too early. The bench also drives conflicting half-bridge commands, which a design without the pair rule would answer with shoot-through. It holds flags high after a cutoff, which would re-enable a design whose cut latch does not hold. It runs a lockout-disabled case and tick-starved cases, where a wrong design would cut off or time out anyway.

// File: rtl/sw_prot_pkg.sv
package sw_prot_pkg;
  // Position of each switch inside its half-bridge pair
  localparam int unsigned SIDE_LOW  = 0;
  localparam int unsigned SIDE_HIGH = 1;
  localparam int unsigned PAIR_W    = 2;

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 1) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/sw_oc_channel.sv
module sw_oc_channel #(
  parameter int unsigned OC_TICKS = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic clr_i,
  input  logic drive_i,
  input  logic oc_i,
  input  logic lock_en_i,
  output logic cut_o,
  output logic trip_o
);
  import sw_prot_pkg::*;
  localparam int unsigned CW = cnt_width(OC_TICKS);
  localparam logic [CW-1:0] LAST = CW'(OC_TICKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cut_q, cut_d;
  logic          active;

  always_comb begin
    active = drive_i & oc_i & lock_en_i;
    trip_o = active & tick_i & (cnt_q == LAST);
    cnt_d  = cnt_q;
    if (!active)
      cnt_d = '0;
    else if (tick_i)
      cnt_d = trip_o ? '0 : cnt_q + 1'b1;
    cut_d = cut_q;
    if (clr_i)
      cut_d = 1'b0;
    else if (trip_o)
      cut_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cut_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      cut_q <= cut_d;
    end
  end

  assign cut_o = cut_q;
endmodule

// File: rtl/sw_ls_delay.sv
module sw_ls_delay #(
  parameter int unsigned LS_DELAY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic req_i,
  output logic on_o
);
  import sw_prot_pkg::*;
  localparam int unsigned CW = cnt_width(LS_DELAY);
  localparam logic [CW-1:0] DONE = CW'(LS_DELAY);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          expired;

  always_comb begin
    expired = (cnt_q == DONE);
    cnt_d   = cnt_q;
    if (!req_i)
      cnt_d = '0;
    else if (tick_i && !expired)
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign on_o = req_i & expired;
endmodule

// File: rtl/sw_ul_window.sv
module sw_ul_window #(
  parameter int unsigned UL_TICKS = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic restart_i,
  output logic blank_o
);
  import sw_prot_pkg::*;
  localparam int unsigned CW = cnt_width(UL_TICKS);
  localparam logic [CW-1:0] END_CNT = CW'(UL_TICKS);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          blank;

  always_comb begin
    blank = (cnt_q != END_CNT);
    cnt_d = cnt_q;
    if (restart_i)
      cnt_d = '0;
    else if (tick_i && blank)
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign blank_o = blank;
endmodule

// File: rtl/sw_prot_timer.sv
module sw_prot_timer #(
  parameter int unsigned NUM_HB   = 6,
  parameter int unsigned OC_TICKS = 50,
  parameter int unsigned UL_TICKS = 300,
  parameter int unsigned LS_DELAY = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_i,
  input  logic                  frame_load_i,
  input  logic [2*NUM_HB-1:0]   cmd_on_i,
  input  logic                  oc_lock_en_i,
  input  logic [2*NUM_HB-1:0]   oc_flag_i,
  input  logic [2*NUM_HB-1:0]   ul_flag_i,
  output logic [2*NUM_HB-1:0]   drive_o,
  output logic                  overload_req_o,
  output logic                  underload_req_o
);
  import sw_prot_pkg::*;
  localparam int unsigned NSW = PAIR_W * NUM_HB;

  logic [NSW-1:0] cmd_q, cmd_d;
  logic [NSW-1:0] cut, trip;
  logic [NSW-1:0] drive;
  logic           ovl_q, ovl_d;
  logic           ulr_q, ulr_d;
  logic           blank;

  // Frame register
  always_comb begin
    cmd_d = frame_load_i ? cmd_on_i : cmd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_q <= '0;
    else        cmd_q <= cmd_d;
  end

  // Per half-bridge: conflict filter and low-side turn-on delay
  for (genvar k = 0; k < NUM_HB; k++) begin : g_bridge
    localparam int unsigned LO = PAIR_W * k + SIDE_LOW;
    localparam int unsigned HI = PAIR_W * k + SIDE_HIGH;
    logic both, ls_req, ls_on;

    assign both   = cmd_q[LO] & cmd_q[HI];
    assign ls_req = cmd_q[LO] & ~both & ~cut[LO];
    assign drive[HI] = cmd_q[HI] & ~both & ~cut[HI];

    sw_ls_delay #(.LS_DELAY(LS_DELAY)) u_lsd (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick_i),
      .req_i  (ls_req),
      .on_o   (ls_on)
    );
    assign drive[LO] = ls_on;
  end

  // Per switch: overcurrent dead-time and cut latch
  for (genvar i = 0; i < NSW; i++) begin : g_sw
    sw_oc_channel #(.OC_TICKS(OC_TICKS)) u_oc (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick_i),
      .clr_i     (frame_load_i),
      .drive_i   (drive[i]),
      .oc_i      (oc_flag_i[i]),
      .lock_en_i (oc_lock_en_i),
      .cut_o     (cut[i]),
      .trip_o    (trip[i])
    );
  end

  // Shared underload blanking window
  sw_ul_window #(.UL_TICKS(UL_TICKS)) u_ulw (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .restart_i (frame_load_i),
    .blank_o   (blank)
  );

  // Status requests
  always_comb begin
    ovl_d = |trip;
    ulr_d = ~blank & (|(drive & ul_flag_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovl_q <= 1'b0;
      ulr_q <= 1'b0;
    end else begin
      ovl_q <= ovl_d;
      ulr_q <= ulr_d;
    end
  end

  assign drive_o         = drive;
  assign overload_req_o  = ovl_q;
  assign underload_req_o = ulr_q;
endmodule

// File: rtl/sw_prot_timer_chk.sv
module sw_prot_timer_chk #(
  parameter int unsigned NUM_HB = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                frame_load_i,
  input logic                oc_lock_en_i,
  input logic [2*NUM_HB-1:0] drive_o,
  input logic                overload_req_o,
  input logic                underload_req_o
);
  // R8: never both switches of a half-bridge
  for (genvar k = 0; k < NUM_HB; k++) begin : g_pair
    a_r8_no_shoot_through: assert property (@(posedge clk) disable iff (!rst_n)
      !(drive_o[2*k] && drive_o[2*k+1]));
  end

  // R2: without lockout and without a new frame, no driven switch drops
  a_r2_no_cut_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    (!oc_lock_en_i && !frame_load_i) |=> (($past(drive_o) & ~drive_o) == '0));

  // R3: an overload request coincides with a switch going off
  a_r3_overload_with_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (overload_req_o && !$past(frame_load_i)) |-> (($past(drive_o) & ~drive_o) != '0));

  // R1: cutoff only while lockout enabled
  a_r1_cut_needs_lockout: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overload_req_o) |-> $past(oc_lock_en_i));

  // R5: a frame load blanks underload requests
  a_r5_blank_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
    frame_load_i |-> ##2 !underload_req_o);
endmodule

bind sw_prot_timer sw_prot_timer_chk #(.NUM_HB(NUM_HB)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .frame_load_i    (frame_load_i),
  .oc_lock_en_i    (oc_lock_en_i),
  .drive_o         (drive_o),
  .overload_req_o  (overload_req_o),
  .underload_req_o (underload_req_o)
);

// File: tb/sw_prot_timer_tb_top.sv
`timescale 1ns/1ps
module sw_prot_timer_tb_top;
  localparam int unsigned NHB = 2;
  localparam int unsigned NS  = 2 * NHB;
  localparam int unsigned OCT = 5;
  localparam int unsigned ULT = 12;
  localparam int unsigned LSD = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          tick;
  logic          frame;
  logic [NS-1:0] cmd, oc, ul, drive;
  logic          lock, ovl, ulr;
  int            n_chk = 0;
  int            n_err = 0;
  bit            done  = 0;

  always #2.5 clk = ~clk;

  sw_prot_timer #(.NUM_HB(NHB), .OC_TICKS(OCT), .UL_TICKS(ULT), .LS_DELAY(LSD)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .frame_load_i(frame), .cmd_on_i(cmd),
    .oc_lock_en_i(lock), .oc_flag_i(oc), .ul_flag_i(ul), .drive_o(drive),
    .overload_req_o(ovl), .underload_req_o(ulr));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Applies a frame; returns at the negedge just after the load edge
  task automatic load(input logic [NS-1:0] c);
    cmd = c; frame = 1'b1;
    step(1);
    frame = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; tick = 1'b1; frame = 1'b0; cmd = '0; oc = '0; ul = '0; lock = 1'b1;
    step(3);
    // R10 reset state
    check("R10 drive", int'(drive), 0);
    check("R10 overload", int'(ovl), 0);
    check("R10 underload", int'(ulr), 0);
    rst_n = 1'b1;
    step(2);

    // R6 high-side drives at once; low-side sweep
    load(4'b0010);
    check("R6 hs immediate", int'(drive), 4'b0010);
    load(4'b0001);
    for (int k = 0; k <= 5; k++) begin
      check("R6 ls delay", int'(drive[0]), (k >= LSD) ? 1 : 0);
      check("R8 pair exclusive", int'(drive[1:0] == 2'b11), 0);
      step(1);
    end
    // R8 conflicting pair, other bridge unaffected
    load(4'b1011);
    for (int k = 0; k < 6; k++) begin
      check("R8 conflict off", int'(drive[1:0]), 0);
      step(1);
    end
    check("R8 other bridge on", int'(drive[3]), 1);

    // R9 ls delay frozen without ticks
    tick = 1'b0;
    load(4'b0100);
    step(10);
    check("R9 no ls without tick", int'(drive[2]), 0);
    tick = 1'b1;
    step(LSD);
    check("R9 ls after ticks", int'(drive[2]), 1);

    // R1/R3 cutoff sweep on high-side of bridge 1
    load(4'b1000);
    oc = 4'b1000;
    for (int n = 1; n <= OCT + 1; n++) begin
      step(1);
      check("R1 cutoff timing", int'(drive[3]), (n >= OCT) ? 0 : 1);
      check("R3 overload pulse", int'(ovl), (n == OCT) ? 1 : 0);
    end
    // R7 stays off while flags clear and recycle
    oc = '0;
    step(10);
    check("R7 stays cut", int'(drive[3]), 0);
    oc = 4'b1000;
    step(3);
    check("R7 stays cut with flag", int'(drive[3]), 0);
    oc = '0;
    load(4'b1000);
    check("R7 re-enabled by frame", int'(drive[3]), 1);

    // R4 restart on flag gap
    oc = 4'b1000;
    step(OCT - 1);
    oc = '0;
    step(1);
    oc = 4'b1000;
    step(OCT - 1);
    check("R4 no cut after restart", int'(drive[3]), 1);
    step(1);
    check("R4 cut after full run", int'(drive[3]), 0);
    oc = '0;

    // R9 no cutoff without ticks
    load(4'b1000);
    tick = 1'b0; oc = 4'b1000;
    step(20);
    check("R9 no cut without tick", int'(drive[3]), 1);
    tick = 1'b1; oc = '0;

    // R2 lockout disabled
    lock = 1'b0;
    load(4'b1000);
    oc = 4'b1000;
    for (int n = 0; n < 20; n++) begin
      step(1);
      check("R2 no cut unlocked", int'({drive[3], ovl}), 2);
    end
    oc = '0; lock = 1'b1;

    // R5 blanking sweep, high-side
    ul = 4'b0010;
    load(4'b0010);
    for (int n = 1; n <= ULT + 2; n++) begin
      step(1);
      check("R5 hs blank window", int'(ulr), (n >= ULT + 1) ? 1 : 0);
    end
    // R5 restart on new frame
    load(4'b0010);
    step(ULT);
    check("R5 restarted window", int'(ulr), 0);
    step(1);
    check("R5 restarted end", int'(ulr), 1);
    // R5 low-side shares the window; off switches ignored
    ul = 4'b1001;
    load(4'b0001);
    step(ULT);
    check("R5 ls blank", int'(ulr), 0);
    step(1);
    check("R5 ls after window", int'(ulr), 1);
    ul = 4'b1000;
    step(2);
    check("R5 off switch ignored", int'(ulr), 0);
    ul = '0;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule